// File: doc/BRIEF.md
# Descriptor Pointer Fetch Queue

This block sits at the front of one work channel. A host writes pointers to job descriptors into a queue through a 64-bit register write port with byte strobes. A separate extended-address register supplies the upper address bits. The channel takes one pointer at a time and reads the eight-doubleword descriptor it points to from memory, one request at a time. It holds the descriptor in a local buffer that can only be read, then pulses a start signal to the processing engine.

When the engine reports that it has finished, the next pointer is taken from the queue. A pointer whose full assembled address is zero is never fetched. It raises an error and halts the channel until a channel reset. Pushing into a full queue drops the pointer and sets a sticky overflow error.

Top module: `desc_fetch_queue`

## Requirements
- R1: A pointer is pushed only when `fetch_we` is high and `fetch_be[0]` (the least significant byte lane) is set. The low address is taken from `fetch_data[ADDR_W-1:0]` and `q_count` rises by one.
- R2: A write to the fetch-address port whose strobes leave `fetch_be[0]` clear pushes nothing. `q_count` is unchanged and no memory request follows.
- R3: The queued pointer is `{extended value, low address}`. The extended value is the one staged by an earlier `ext_we`, or the `ext_data` value of an `ext_we` in the same cycle as the push.
- R4: The queue holds at most DEPTH (24) pointers. A push while it is full is dropped, leaves `q_count` at DEPTH and sets `err_ovf`, which stays set.
- R5: Pointers are taken in arrival order. Each descriptor read issues eight requests at pointer+8*k for k = 0..7, each a one-cycle `rd_req`. The next request is not issued until the previous `rsp_valid` has arrived.
- R6: After the eighth response, `db_valid` rises and `eng_start` pulses for one cycle. `db_data` then returns the k-th response for `db_idx` = k.
- R7: No pointer is taken while a fetch or execution is in progress. The next pointer is taken only after `eng_done` is seen in the running state.
- R8: A pointer whose full assembled address is zero is not fetched. It sets `err_zero` and `halted`, and no further `rd_req` is issued. Queued entries and `eng_done` are ignored until a channel reset.
- R9: A pointer with a zero low part and a nonzero extended part is a valid pointer and is fetched.
- R10: A `chan_rst` pulse empties the queue, clears `err_zero`, `err_ovf`, `halted` and `db_valid`, and returns the channel to idle, ready to take new pointers.
- R11: After `rst_n` is released, `q_count` is 0, no error or halt flag is set, `db_valid` is low and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset: empties queue, clears errors |
| fetch_we | input | 1 | Host write to the fetch-address register |
| fetch_be | input | 8 | Byte strobes of that write; bit 0 is the least significant lane |
| fetch_data | input | 64 | Write data; low ADDR_W bits hold the pointer |
| ext_we | input | 1 | Host write to the extended-address register |
| ext_data | input | EXT_W | Extended (upper) address bits |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | EXT_W+ADDR_W | Doubleword address of the request |
| rsp_valid | input | 1 | Memory response valid |
| rsp_data | input | 64 | Memory response doubleword |
| eng_start | output | 1 | One-cycle start pulse to the processing engine |
| eng_done | input | 1 | Engine finished the current descriptor |
| db_idx | input | 3 | Descriptor buffer doubleword select |
| db_data | output | 64 | Selected descriptor buffer doubleword |
| db_valid | output | 1 | Descriptor buffer holds a complete descriptor |
| q_count | output | $clog2(DEPTH+1) | Number of queued pointers |
| halted | output | 1 | Channel stopped by a zero pointer |
| err_zero | output | 1 | Zero-pointer error |
| err_ovf | output | 1 | Sticky queue-overflow error |

## Verification
The fetch path is driven with a table of pointers: a low-only address, one with mid extended bits, one near the top of the address space, and one with a zero low part. The table alternates between staging the extended bits ahead of the push and writing them in the same cycle. The memory model returns data that encodes the request address, so each buffer doubleword shows whether the right base, offset and extended bits were used. Directed cases then cover upper-lane-only writes, a second pointer arriving during execution, filling the queue past its depth, and a zero pointer followed by a valid one before and after a channel reset.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
   localparam int DW    = 64;
   localparam int BEATS = 8;
   localparam int BEAT_W = $clog2(BEATS);

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_REQ,
      SQ_WAIT,
      SQ_RUN,
      SQ_HALT
   } sq_state_t;
endpackage

// File: rtl/dfq_push.sv
module dfq_push #(
   parameter int ADDR_W = 32,
   parameter int EXT_W  = 4,
   parameter bit EXT_EN = 1'b1,
   localparam int FULL_W = EXT_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_we,
   input  logic [7:0]        fetch_be,
   input  logic [63:0]       fetch_data,
   input  logic              ext_we,
   input  logic [EXT_W-1:0]  ext_data,
   output logic              push_v,
   output logic [FULL_W-1:0] push_addr
);
   logic [EXT_W-1:0] ext_cur;

   generate
      if (EXT_EN) begin : g_ext
         logic [EXT_W-1:0] ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ext_q <= '0;
            else if (ext_we) ext_q <= ext_data;
         end
         // a same-cycle extended write is joined with the push
         assign ext_cur = ext_we ? ext_data : ext_q;
      end else begin : g_noext
         assign ext_cur = '0;
      end
   endgenerate

   assign push_v    = fetch_we & fetch_be[0];
   assign push_addr = {ext_cur, fetch_data[ADDR_W-1:0]};
endmodule

// File: rtl/dfq_ptr_fifo.sv
module dfq_ptr_fifo #(
   parameter int DEPTH = 24,
   parameter int W     = 36,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic             empty,
   output logic             drop,
   output logic [CNT_W-1:0] count
);
   logic [W-1:0]     mem [DEPTH];
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             full, wr_ok, rd_ok;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign wr_ok = push & ~full;
   assign rd_ok = pop & ~empty;
   assign drop  = push & full;
   assign rdata = mem[rd_idx];

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
      return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_idx <= step(wr_idx);
         if (rd_ok) rd_idx <= step(rd_idx);
         count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_idx] <= wdata;
   end
endmodule

// File: rtl/dfq_seq.sv
module dfq_seq
   import dfq_pkg::*;
#(
   parameter int W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              q_empty,
   input  logic [W-1:0]      q_head,
   output logic              q_pop,
   output logic              rd_req,
   output logic [W-1:0]      rd_addr,
   input  logic              rsp_valid,
   input  logic [DW-1:0]     rsp_data,
   output logic              eng_start,
   input  logic              eng_done,
   input  logic [BEAT_W-1:0] db_idx,
   output logic [DW-1:0]     db_data,
   output logic              db_valid,
   output logic              halted,
   output logic              err_zero
);
   sq_state_t         state;
   logic [W-1:0]      base;
   logic [BEAT_W-1:0] beat;
   logic [DW-1:0]     db_q [BEATS];

   assign q_pop   = (state == SQ_IDLE) & ~q_empty;
   assign rd_req  = (state == SQ_REQ);
   assign rd_addr = base + (W'(beat) << 3);
   assign halted  = (state == SQ_HALT);
   assign db_data = db_q[db_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         base      <= '0;
         beat      <= '0;
         db_valid  <= 1'b0;
         eng_start <= 1'b0;
         err_zero  <= 1'b0;
      end else if (clr) begin
         state     <= SQ_IDLE;
         beat      <= '0;
         db_valid  <= 1'b0;
         eng_start <= 1'b0;
         err_zero  <= 1'b0;
      end else begin
         eng_start <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (!q_empty) begin
                  db_valid <= 1'b0;
                  if (q_head == '0) begin
                     err_zero <= 1'b1;
                     state    <= SQ_HALT;
                  end else begin
                     base  <= q_head;
                     beat  <= '0;
                     state <= SQ_REQ;
                  end
               end
            end
            SQ_REQ: state <= SQ_WAIT;
            SQ_WAIT: begin
               if (rsp_valid) begin
                  if (beat == BEAT_W'(BEATS - 1)) begin
                     db_valid  <= 1'b1;
                     eng_start <= 1'b1;
                     state     <= SQ_RUN;
                  end else begin
                     beat  <= beat + 1'b1;
                     state <= SQ_REQ;
                  end
               end
            end
            SQ_RUN:  if (eng_done) state <= SQ_IDLE;
            SQ_HALT: state <= SQ_HALT;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state == SQ_WAIT && rsp_valid) db_q[beat] <= rsp_data;
   end
endmodule

// File: rtl/desc_fetch_queue.sv
module desc_fetch_queue
   import dfq_pkg::*;
#(
   parameter int DEPTH  = 24,
   parameter int ADDR_W = 32,
   parameter int EXT_W  = 4,
   parameter bit EXT_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       chan_rst,
   input  logic                       fetch_we,
   input  logic [7:0]                 fetch_be,
   input  logic [63:0]                fetch_data,
   input  logic                       ext_we,
   input  logic [EXT_W-1:0]           ext_data,
   output logic                       rd_req,
   output logic [EXT_W+ADDR_W-1:0]    rd_addr,
   input  logic                       rsp_valid,
   input  logic [63:0]                rsp_data,
   output logic                       eng_start,
   input  logic                       eng_done,
   input  logic [2:0]                 db_idx,
   output logic [63:0]                db_data,
   output logic                       db_valid,
   output logic [$clog2(DEPTH+1)-1:0] q_count,
   output logic                       halted,
   output logic                       err_zero,
   output logic                       err_ovf
);
   localparam int FULL_W = EXT_W + ADDR_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie in 4..64");
      end
      if (EXT_W < 1 || FULL_W > 64) begin : g_bad_ext
         $error("EXT_W must be at least 1 and EXT_W+ADDR_W at most 64");
      end
   endgenerate

   logic              push_v, q_pop, q_empty, q_drop;
   logic [FULL_W-1:0] push_addr, q_head;

   dfq_push #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .EXT_EN(EXT_EN)) u_push (
      .clk, .rst_n, .fetch_we, .fetch_be, .fetch_data, .ext_we, .ext_data,
      .push_v, .push_addr
   );

   dfq_ptr_fifo #(.DEPTH(DEPTH), .W(FULL_W)) u_fifo (
      .clk, .rst_n, .clr(chan_rst), .push(push_v), .wdata(push_addr),
      .pop(q_pop), .rdata(q_head), .empty(q_empty), .drop(q_drop),
      .count(q_count)
   );

   dfq_seq #(.W(FULL_W)) u_seq (
      .clk, .rst_n, .clr(chan_rst), .q_empty, .q_head, .q_pop,
      .rd_req, .rd_addr, .rsp_valid, .rsp_data, .eng_start, .eng_done,
      .db_idx, .db_data, .db_valid, .halted, .err_zero
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_ovf <= 1'b0;
      else if (chan_rst) err_ovf <= 1'b0;
      else if (q_drop)   err_ovf <= 1'b1;
   end
endmodule

// File: rtl/dfq_chk.sv
module dfq_chk #(
   parameter int DEPTH = 24,
   parameter int W     = 36
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       chan_rst,
   input logic                       rd_req,
   input logic [W-1:0]               rd_addr,
   input logic                       eng_start,
   input logic                       db_valid,
   input logic [$clog2(DEPTH+1)-1:0] q_count,
   input logic                       halted,
   input logic                       err_zero,
   input logic                       err_ovf
);
   // R8
   halt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !rd_req);
   // R8
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !chan_rst) |=> halted);
   // R5
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   // R5
   dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[2:0] == 3'b000));
   // R6
   start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> db_valid);
   // R6
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= ($clog2(DEPTH+1))'(DEPTH));
   // R10
   chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> (q_count == '0 && !halted && !err_zero && !err_ovf && !db_valid));
endmodule

bind desc_fetch_queue dfq_chk #(.DEPTH(DEPTH), .W(EXT_W + ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .rd_req(rd_req),
   .rd_addr(rd_addr), .eng_start(eng_start), .db_valid(db_valid),
   .q_count(q_count), .halted(halted), .err_zero(err_zero), .err_ovf(err_ovf)
);

// File: tb/desc_fetch_queue_tb.sv
`timescale 1ns/1ps
module desc_fetch_queue_tb;
   localparam int DEPTH = 24;
   localparam int AW    = 36;
   localparam int NV    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chan_rst = 1'b0;
   logic          fetch_we = 1'b0;
   logic [7:0]    fetch_be = '0;
   logic [63:0]   fetch_data = '0;
   logic          ext_we = 1'b0;
   logic [3:0]    ext_data = '0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rsp_valid;
   logic [63:0]   rsp_data;
   logic          eng_start;
   logic          eng_done = 1'b0;
   logic [2:0]    db_idx = '0;
   logic [63:0]   db_data;
   logic          db_valid;
   logic [4:0]    q_count;
   logic          halted, err_zero, err_ovf;

   int checks = 0;
   int errors = 0;
   int n_req  = 0;

   always #4 clk = ~clk;

   desc_fetch_queue u_dut (
      .clk, .rst_n, .chan_rst, .fetch_we, .fetch_be, .fetch_data, .ext_we,
      .ext_data, .rd_req, .rd_addr, .rsp_valid, .rsp_data, .eng_start,
      .eng_done, .db_idx, .db_data, .db_valid, .q_count, .halted,
      .err_zero, .err_ovf
   );

   function automatic logic [63:0] memf(input logic [AW-1:0] a);
      return {28'hC0DE5A1, a};
   endfunction

   // memory model: one-cycle response carrying the address it was asked for
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_req;
         rsp_data  <= memf(rd_addr);
         if (rd_req) n_req = n_req + 1;
      end
   end

   localparam logic [AW-1:0] VEC_PTR  [NV] = '{36'h0_0000_1000, 36'h3_8000_0040,
                                              36'hF_FFFF_FFC0, 36'h5_0000_0000};
   localparam bit            VEC_SAME [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [AW-1:0] p, input logic [7:0] be, input bit same);
      @(negedge clk);
      fetch_we   = 1'b1;
      fetch_be   = be;
      fetch_data = {32'hDEAD_BEEF, p[31:0]};
      if (same) begin
         ext_we   = 1'b1;
         ext_data = p[35:32];
      end
      @(negedge clk);
      fetch_we = 1'b0;
      ext_we   = 1'b0;
   endtask

   task automatic stage_ext(input logic [3:0] e);
      @(negedge clk);
      ext_we   = 1'b1;
      ext_data = e;
      @(negedge clk);
      ext_we = 1'b0;
   endtask

   task automatic wait_start(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (eng_start) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic done_pulse();
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   task automatic creset();
      @(negedge clk);
      chan_rst = 1'b1;
      @(negedge clk);
      chan_rst = 1'b0;
   endtask

   task automatic check_db(input string req, input logic [AW-1:0] p);
      for (int k = 0; k < 8; k++) begin
         db_idx = 3'(k);
         #1;
         chk(req, db_data, memf(p + AW'(8 * k)));
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit seen;
      int r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 q_count", 64'(q_count), 0);
      chk("R11 flags", {61'b0, halted, err_zero, err_ovf}, 0);
      chk("R11 db_valid/rd_req", {62'b0, db_valid, rd_req}, 0);

      // R2 upper lanes only: no push
      push(36'h0_0000_1000, 8'hFE, 1'b0);
      chk("R2 q_count", 64'(q_count), 0);
      repeat (5) @(negedge clk);
      chk("R2 no request", 64'(n_req), 0);

      // table walk: R1 R3 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         if (!VEC_SAME[v]) stage_ext(VEC_PTR[v][35:32]);
         r0 = n_req;
         push(VEC_PTR[v], 8'h01, VEC_SAME[v]);
         chk("R1 q_count after push", 64'(q_count), 1);
         wait_start(seen);
         chk("R6 start seen", 64'(seen), 1);
         chk("R6 db_valid", 64'(db_valid), 1);
         chk("R5 eight requests", 64'(n_req - r0), 8);
         check_db((v == 3) ? "R9 buffer" : "R3 R5 buffer", VEC_PTR[v]);
         done_pulse();
      end

      // R7 no pop while running; pop after done
      stage_ext(4'h0);
      push(36'h0_0000_4000, 8'hFF, 1'b0);
      wait_start(seen);
      r0 = n_req;
      push(36'h0_0000_5000, 8'hFF, 1'b0);
      repeat (6) @(negedge clk);
      chk("R7 q held", 64'(q_count), 1);
      chk("R7 no request while running", 64'(n_req - r0), 0);
      done_pulse();
      wait_start(seen);
      chk("R7 next start", 64'(seen), 1);
      chk("R7 q drained", 64'(q_count), 0);
      check_db("R5 order", 36'h0_0000_5000);
      done_pulse();

      // R4 overflow while engine busy
      push(36'h0_0000_6000, 8'hFF, 1'b0);
      wait_start(seen);
      for (int i = 0; i < DEPTH; i++) push(36'h0_0001_0000 + AW'(i * 64), 8'h01, 1'b0);
      chk("R4 full count", 64'(q_count), DEPTH);
      chk("R4 no error yet", 64'(err_ovf), 0);
      push(36'h0_0009_0000, 8'h01, 1'b0);
      chk("R4 dropped", 64'(q_count), DEPTH);
      chk("R4 err_ovf", 64'(err_ovf), 1);
      repeat (3) @(negedge clk);
      chk("R4 sticky", 64'(err_ovf), 1);
      creset();
      chk("R10 cleared", {59'b0, q_count == 0, halted, err_zero, err_ovf, db_valid}, 64'h10);

      // R8 zero pointer halts
      r0 = n_req;
      push(36'h0_0000_0000, 8'hFF, 1'b0);
      push(36'h0_0000_7000, 8'hFF, 1'b0);
      repeat (3) @(negedge clk);
      done_pulse();
      repeat (15) @(negedge clk);
      chk("R8 halted", {62'b0, halted, err_zero}, 3);
      chk("R8 queued ignored", 64'(q_count), 1);
      chk("R8 no request", 64'(n_req - r0), 0);
      creset();
      chk("R10 after halt", {59'b0, q_count == 0, halted, err_zero, err_ovf, db_valid}, 64'h10);
      push(36'h0_0000_8000, 8'hFF, 1'b0);
      wait_start(seen);
      chk("R10 resumes", 64'(seen), 1);
      check_db("R10 buffer", 36'h0_0000_8000);
      done_pulse();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule